// File: doc/BRIEF.md
# BCD Countdown Timer (hours, minutes, seconds)

The block holds a countdown value as three two-digit BCD fields: hours (00 to 23), minutes (00 to 59) and seconds (00 to 59). A one-cycle `tick` strobe marks each second. While `run` is high, every tick removes one second from the value. The borrow passes from seconds into minutes and from minutes into hours. The count stops at 00:00:00. When it arrives there it raises `done` for one clock cycle.

The value is preset with a single field-select key and two adjust inputs. The key steps the selected field through hours, minutes and seconds, then back to hours. Each tick that finds `up` or `down` high moves the selected field by one step, so a held adjust input steps the field at the tick rate. Adjustment wraps inside the field and never carries into a neighbour. A warning flag is high during the last ten seconds of a countdown. Tone generation and display driving belong to other blocks.

Top module: `bcd_countdown_timer`

## Requirements
- R1: After reset the value reads 00:00:00, `done` is low and the selected field is hours.
- R2: On a tick with `run` high, no adjust input high and a non-zero value, the value drops by one second. Seconds 00 borrows to 59 with minutes minus one. Minutes 00 with seconds 00 borrows to 59:59 with hours minus one.
- R3: On a tick with `run` low and no adjust input high, the value does not change.
- R4: At 00:00:00 with `run` high and no adjust input, the value stays 00:00:00 and does not wrap.
- R5: `done` is high for exactly one clock cycle. That cycle is the first cycle in which a countdown tick has brought the value to 00:00:00. A tick that finds the value already zero raises no `done`.
- R6: Each one-cycle `sel_key` pulse advances the selection in the order hours, minutes, seconds, hours. A `sel_key` pulse on its own does not change the value.
- R7: A tick with `up` high adds one to the selected field only. Hours wrap from 23 to 00, and minutes and seconds wrap from 59 to 00.
- R8: A tick with `down` high and `up` low subtracts one from the selected field only. Hours wrap from 00 to 23, and minutes and seconds wrap from 00 to 59, with no borrow from other fields.
- R9: When `up` and `down` are both high on a tick, the tick increments.
- R10: An adjust on a tick takes priority over counting, and no countdown step happens on that tick.
- R11: `final_ten` is high exactly when hours read 00, minutes read 00 and the seconds tens digit is 0.
- R12: The value changes only on clock edges where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle strobe once per second |
| run | input | 1 | Count enable, sampled on ticks |
| sel_key | input | 1 | One-cycle pulse that advances the selected field |
| up | input | 1 | Increment the selected field on a tick |
| down | input | 1 | Decrement the selected field on a tick |
| hours | output | 8 | Hours BCD, tens in [7:4], units in [3:0] |
| minutes | output | 8 | Minutes BCD, tens in [7:4], units in [3:0] |
| seconds | output | 8 | Seconds BCD, tens in [7:4], units in [3:0] |
| final_ten | output | 1 | Last-ten-seconds warning |
| done | output | 1 | One-cycle pulse on reaching zero |

## Verification
Adjusting and counting can both claim the same tick. A tick arrives with `run` high while `up` is held, and seconds sit at 58. The value must read 59 and not 57 or 58, because the adjust wins and no countdown step is taken. A second collision is `up` and `down` held together on one tick: the selected seconds field must wrap upward from 59 to 00 and must not fall to 58.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int N_FIELDS = 3;  // index 0 hours, 1 minutes, 2 seconds

  // highest tens digit a field may hold
  function automatic int field_tens_lim(int idx);
    return (idx == 0) ? 2 : 5;
  endfunction

  // highest units digit when tens sits at its limit
  function automatic int field_units_lim(int idx);
    return (idx == 0) ? 3 : 9;
  endfunction

endpackage

// File: rtl/cdt_field_sel.sv
module cdt_field_sel #(
  parameter int N_FIELDS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_key,
  output logic [N_FIELDS-1:0] sel
);

  logic [N_FIELDS-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (sel_key) sel_d = {sel_q[N_FIELDS-2:0], sel_q[N_FIELDS-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= {{(N_FIELDS-1){1'b0}}, 1'b1};
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) == 1);

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_key |=> $stable(sel_q));

endmodule

// File: rtl/cdt_bcd_field.sv
module cdt_bcd_field #(
  parameter int DIGIT_W   = 4,
  parameter int TENS_LIM  = 5,
  parameter int UNITS_LIM = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc,
  input  logic                 dec,
  output logic [2*DIGIT_W-1:0] value,
  output logic                 is_zero
);

  localparam int FW = 2 * DIGIT_W;
  localparam logic [DIGIT_W-1:0] TL   = DIGIT_W'(TENS_LIM);
  localparam logic [DIGIT_W-1:0] UL   = DIGIT_W'(UNITS_LIM);
  localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  logic [DIGIT_W-1:0] tens_q, units_q, tens_d, units_d;
  logic               at_top, at_zero;

  assign at_top  = (tens_q == TL) && (units_q == UL);
  assign at_zero = (tens_q == '0) && (units_q == '0);

  always_comb begin
    tens_d  = tens_q;
    units_d = units_q;
    if (inc) begin
      if (at_top) begin
        tens_d  = '0;
        units_d = '0;
      end else if (units_q == NINE) begin
        tens_d  = tens_q + ONE;
        units_d = '0;
      end else begin
        units_d = units_q + ONE;
      end
    end else if (dec) begin
      if (at_zero) begin
        tens_d  = TL;
        units_d = UL;
      end else if (units_q == '0) begin
        tens_d  = tens_q - ONE;
        units_d = NINE;
      end else begin
        units_d = units_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q  <= '0;
      units_q <= '0;
    end else if (inc || dec) begin
      tens_q  <= tens_d;
      units_q <= units_d;
    end
  end

  assign value   = {tens_q, units_q};
  assign is_zero = at_zero;

  // R7
  field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (units_q <= NINE) && ((tens_q < TL) || ((tens_q == TL) && (units_q <= UL))));

  // R9
  inc_dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));

  // R8
  dec_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && at_zero) |=> (value == {TL, UL}));

endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer #(
  parameter int DIGIT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 run,
  input  logic                 sel_key,
  input  logic                 up,
  input  logic                 down,
  output logic [2*DIGIT_W-1:0] hours,
  output logic [2*DIGIT_W-1:0] minutes,
  output logic [2*DIGIT_W-1:0] seconds,
  output logic                 final_ten,
  output logic                 done
);

  import cdt_pkg::*;

  localparam int FW    = 2 * DIGIT_W;
  localparam int F_HR  = 0;
  localparam int F_MIN = 1;
  localparam int F_SEC = N_FIELDS - 1;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_q1, rst_q2, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign rst_sync_n = rst_q2;

  logic [N_FIELDS-1:0] sel, is_zero, fld_inc, fld_dec, borrow;
  logic [FW-1:0]       fld_val [N_FIELDS];
  logic                adj_req, step_up, step_dn, all_zero, count_en, last_sec;
  logic                done_d, done_q;

  cdt_field_sel #(.N_FIELDS(N_FIELDS)) i_sel (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_key (sel_key),
    .sel     (sel)
  );

  assign adj_req  = tick && (up || down);
  assign step_up  = tick && up;
  assign step_dn  = tick && down && !up;
  assign all_zero = &is_zero;
  assign count_en = tick && run && !(up || down) && !all_zero;

  // borrow chain from seconds towards hours
  always_comb begin
    borrow[F_SEC] = 1'b1;
    for (int i = N_FIELDS - 2; i >= 0; i--) begin
      borrow[i] = borrow[i+1] && is_zero[i+1];
    end
  end

  always_comb begin
    for (int i = 0; i < N_FIELDS; i++) begin
      fld_inc[i] = step_up && sel[i];
      fld_dec[i] = (step_dn && sel[i]) || (count_en && borrow[i]);
    end
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    cdt_bcd_field #(
      .DIGIT_W   (DIGIT_W),
      .TENS_LIM  (field_tens_lim(g)),
      .UNITS_LIM (field_units_lim(g))
    ) i_field (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .inc     (fld_inc[g]),
      .dec     (fld_dec[g]),
      .value   (fld_val[g]),
      .is_zero (is_zero[g])
    );
  end

  assign last_sec = is_zero[F_HR] && is_zero[F_MIN] && (fld_val[F_SEC] == FW'(1));
  assign done_d   = count_en && last_sec;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign hours     = fld_val[F_HR];
  assign minutes   = fld_val[F_MIN];
  assign seconds   = fld_val[F_SEC];
  assign final_ten = is_zero[F_HR] && is_zero[F_MIN] &&
                     (fld_val[F_SEC][FW-1:DIGIT_W] == '0);
  assign done      = done_q;

  // R12
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick |=> $stable({hours, minutes, seconds}));

  // R3
  run_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !run && !up && !down) |=> $stable({hours, minutes, seconds}));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (all_zero && !adj_req) |=> all_zero);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);

  // R5
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> (all_zero && final_ten));

  // R10
  adjust_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adj_req |-> !count_en);

endmodule

// File: tb/test_bcd_countdown_timer.sv
module test_bcd_countdown_timer;

  logic       clk = 1'b0;
  logic       rst_n, tick, run, sel_key, up, down;
  logic [7:0] hours, minutes, seconds;
  logic       final_ten, done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bcd_countdown_timer i_bcd_countdown_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run),
    .sel_key   (sel_key),
    .up        (up),
    .down      (down),
    .hours     (hours),
    .minutes   (minutes),
    .seconds   (seconds),
    .final_ten (final_ten),
    .done      (done)
  );

  localparam logic [3:0] OP_SEL   = 4'd0;
  localparam logic [3:0] OP_UP    = 4'd1;
  localparam logic [3:0] OP_DN    = 4'd2;
  localparam logic [3:0] OP_BOTH  = 4'd3;
  localparam logic [3:0] OP_RUN   = 4'd4;
  localparam logic [3:0] OP_IDLE  = 4'd5;
  localparam logic [3:0] OP_RUNUP = 4'd6;
  localparam logic [3:0] OP_WAIT  = 4'd7;

  // entry: {requirement number, operation, expected hh mm ss in BCD}
  localparam int NV = 23;
  localparam logic [31:0] VEC [NV] = '{
    {4'd8,  OP_DN,    24'h230000},  // R8 hours 00 -> 23
    {4'd7,  OP_UP,    24'h000000},  // R7 hours 23 -> 00
    {4'd7,  OP_UP,    24'h010000},  // R7
    {4'd6,  OP_SEL,   24'h010000},  // R6 -> minutes
    {4'd8,  OP_DN,    24'h015900},  // R8 minutes 00 -> 59, no borrow
    {4'd7,  OP_UP,    24'h010000},  // R7 minutes 59 -> 00, no carry
    {4'd7,  OP_UP,    24'h010100},  // R7
    {4'd6,  OP_SEL,   24'h010100},  // R6 -> seconds
    {4'd7,  OP_UP,    24'h010101},  // R7
    {4'd8,  OP_DN,    24'h010100},  // R8
    {4'd8,  OP_DN,    24'h010159},  // R8 seconds 00 -> 59
    {4'd6,  OP_SEL,   24'h010159},  // R6 -> hours
    {4'd6,  OP_UP,    24'h020159},  // R6 hours selected again
    {4'd6,  OP_SEL,   24'h020159},  // R6 -> minutes
    {4'd6,  OP_SEL,   24'h020159},  // R6 -> seconds
    {4'd9,  OP_BOTH,  24'h020100},  // R9 up wins, 59 -> 00
    {4'd2,  OP_RUN,   24'h020059},  // R2 minute borrow
    {4'd2,  OP_RUN,   24'h020058},  // R2
    {4'd3,  OP_IDLE,  24'h020058},  // R3
    {4'd10, OP_RUNUP, 24'h020059},  // R10 adjust beats count
    {4'd7,  OP_UP,    24'h020000},  // R7
    {4'd2,  OP_RUN,   24'h015959},  // R2 hour borrow
    {4'd12, OP_WAIT,  24'h015959}   // R12 no change without tick
  };

  task automatic apply(input logic [3:0] op);
    @(negedge clk);
    case (op)
      OP_SEL:   sel_key = 1'b1;
      OP_UP:    begin tick = 1'b1; up = 1'b1; end
      OP_DN:    begin tick = 1'b1; down = 1'b1; end
      OP_BOTH:  begin tick = 1'b1; up = 1'b1; down = 1'b1; end
      OP_RUN:   begin tick = 1'b1; run = 1'b1; end
      OP_IDLE:  tick = 1'b1;
      OP_RUNUP: begin tick = 1'b1; run = 1'b1; up = 1'b1; end
      OP_WAIT:  begin
        run = 1'b1;
        repeat (8) @(negedge clk);
      end
      default:  ;
    endcase
    @(negedge clk);
    tick = 1'b0; run = 1'b0; sel_key = 1'b0; up = 1'b0; down = 1'b0;
  endtask

  task automatic check_val(input int req, input logic [23:0] exp);
    checks++;
    if ({hours, minutes, seconds} !== exp) begin
      errors++;
      $display("FAIL R%0d value actual=%h expected=%h", req,
               {hours, minutes, seconds}, exp);
    end
  endtask

  task automatic check_bit(input int req, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    tick = 1'b0; run = 1'b0; sel_key = 1'b0; up = 1'b0; down = 1'b0;
    do_reset();

    // R1 reset state
    check_val(1, 24'h000000);
    check_bit(1, "done", done, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27:24]);
      check_val(int'(VEC[i][31:28]), VEC[i][23:0]);
    end

    // R1 reset again from a non-zero value; hours selected afterwards
    do_reset();
    check_val(1, 24'h000000);
    check_bit(11, "final_ten", final_ten, 1'b1);  // R11 at zero
    apply(OP_UP);
    check_val(1, 24'h010000);   // R1 selection is hours
    apply(OP_DN);
    apply(OP_SEL);
    apply(OP_SEL);
    for (int i = 0; i < 12; i++) apply(OP_UP);
    check_val(7, 24'h000012);   // R7

    apply(OP_RUN);
    check_val(2, 24'h000011);
    check_bit(11, "final_ten", final_ten, 1'b0);  // R11 tens digit 1
    apply(OP_RUN);
    check_bit(11, "final_ten", final_ten, 1'b0);  // R11 at 10
    apply(OP_RUN);
    check_val(2, 24'h000009);
    check_bit(11, "final_ten", final_ten, 1'b1);  // R11 at 09

    for (int i = 0; i < 8; i++) begin
      apply(OP_RUN);
      check_bit(5, "done early", done, 1'b0);     // R5
    end
    check_val(2, 24'h000001);

    apply(OP_RUN);
    check_val(4, 24'h000000);
    check_bit(5, "done at zero", done, 1'b1);     // R5
    @(negedge clk);
    check_bit(5, "done width", done, 1'b0);       // R5 one cycle only

    apply(OP_RUN);
    check_val(4, 24'h000000);                     // R4 no wrap
    check_bit(5, "done on held zero", done, 1'b0);
    apply(OP_RUN);
    check_val(4, 24'h000000);

    apply(OP_SEL);                                // seconds -> hours
    apply(OP_UP);
    check_val(11, 24'h010000);
    check_bit(11, "final_ten hours set", final_ten, 1'b0);  // R11

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule